// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block is the address-update stage of a small signal-processing core. It holds four address registers. Each address register has a partner index register and a partner wrap register. One decoded operation arrives per clock. The operation steps the chosen address register up or down by one, or adds or subtracts its partner index register. The result always stays inside a circular buffer, and the length of that buffer is set by the partner wrap register.

The wrap decision never divides. A mask is built by copying the highest set bit of the wrap value into every lower bit. The low bits of the address and the index, taken under that mask, are then compared against simple limits. Index addition and index subtraction each have their own compare path for positive, negative and edge index values.

A plain write port loads any of the twelve registers. Each valid operation returns the new address one clock later, together with a done strobe.

Top module: `modulo_agu`

## Requirements
- R1: Write select values 0..3 load address register 0..3, values 4..7 load index register 0..3, and values 8..11 load wrap register 0..3. Select values 12..15 change no register.
- R2: Recognised opcodes, with n = op_code_i[1:0]:
  - `(op & 0xFFFC) == 0x0004` is decrement.
  - `(op & 0xFFFC) == 0x0008` is increment.
  - `(op & 0xFFFC) == 0x000C` is subtract-index.
  - `(op & 0xFFF0) == 0x0010` is add-index.
  - Any other code with op_valid_i high leaves done_o low, leaves addr_o unchanged and changes no register.
- R3: The wrap mask m is the wrap value with every bit below its highest set bit also set, then ORed with 1. A wrap value of 0 gives m = 1, so the address stays fixed under increment and decrement.
- R4: Increment gives a = ar+1. If (a XOR ar) ≥ (2·wr)|1, compared unsigned at 17 bits, the result is a − (wr+1); otherwise it is a.
- R5: Decrement gives a = ar−1. If the signed value (ar AND m) − 1 is below m − wr, the result is a + wr + 1; otherwise it is a.
- R6: Add-index gives a = ar+ix, with t = (ar AND m) + (ix AND m) − m − 1 taken signed.
  - If ix bit 15 is clear and t ≥ 0, the result is a − (wr+1).
  - If ix bit 15 is set and t < m − wr, the result is a + wr + 1.
  - In every other case the result is a.
- R7: Subtract-index gives a = ar−ix, with t = (ar AND m) − (ix AND m) taken signed.
  - If ix > 0x8000 unsigned and t ≥ 0, the result is a − (wr+1).
  - If ix ≤ 0x8000 and t < m − wr, the result is a + wr + 1.
  - In every other case the result is a.
- R8: Add-index uses the index register that matches the destination, bits 1:0. When the source field, bits 3:2, differs from the destination, idx_flag_o is high together with done_o. In every other case idx_flag_o is low.
- R9: The new address is written to the address register and shown on addr_o, and done_o pulses, at the first clock edge after the operation is presented. With no operation, done_o is low and addr_o holds its value.
- R10: Reset, active low and asynchronous, clears all twelve registers, addr_o, done_o and idx_flag_o to zero.
- R11: A write to the address register that an operation updates in the same cycle is overridden by the operation's result. The operation reads register values from before that cycle's write.
- R12: All results are taken modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_code_i | input | 16 | Operation code word |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 4 | Register select for the write |
| wr_data_i | input | 16 | Write data |
| addr_o | output | 16 | Most recent updated address |
| done_o | output | 1 | Pulses for one cycle after a recognised operation |
| idx_flag_o | output | 1 | Add-index source field differed from the destination |

## Verification
The bench builds the block with its default parameters: a 16-bit address width and four address registers. At that width the hard edges of the update rules can all be reached. These include a wrap value of 0xFFFF, where the buffer spans the whole space, and a wrap value of 0, where the address is fixed. They also include the index values 0, 0x7FFF, 0x8000 and 0xFFFF, which choose between the forward and backward compare paths. A random sweep over those edges and over random values is compared against a reference that finds the highest set bit by scanning, not by smearing.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_INC,
    OP_DEC,
    OP_ADDIX,
    OP_SUBIX
  } agu_op_e;
endpackage

// File: rtl/agu_mask.sv
module agu_mask #(
  parameter int W = 16
) (
  input  logic [W-1:0] wr_i,
  output logic [W-1:0] m_o
);
  localparam int ST = $clog2(W);
  logic [W-1:0] smear [ST+1];

  assign smear[0] = wr_i;
  for (genvar g = 0; g < ST; g++) begin : g_smear
    assign smear[g+1] = smear[g] | (smear[g] >> (1 << g));
  end
  assign m_o = smear[ST] | W'(1);
endmodule

// File: rtl/agu_next.sv
module agu_next
  import agu_pkg::*;
#(
  parameter int W = 16
) (
  input  agu_op_e      op_i,
  input  logic [W-1:0] ar_i,
  input  logic [W-1:0] ix_i,
  input  logic [W-1:0] wr_i,
  output logic [W-1:0] nar_o
);
  localparam int XW = W + 2;

  logic [W-1:0] m, wr_p1, am, xm;
  logic [W-1:0] a_inc, a_dec, a_add, a_sub;
  logic signed [XW-1:0] am_s, xm_s, m_s, lim_s, t_dec, t_add, t_sub;
  logic inc_wrap, dec_wrap, add_fwd, add_back, sub_neg, sub_fwd, sub_back;

  agu_mask #(.W(W)) u_mask (.wr_i(wr_i), .m_o(m));

  assign wr_p1 = wr_i + W'(1);
  assign am    = ar_i & m;
  assign xm    = ix_i & m;
  assign am_s  = {2'b00, am};
  assign xm_s  = {2'b00, xm};
  assign m_s   = {2'b00, m};
  assign lim_s = m_s - {2'b00, wr_i};

  // increment: carry span reaching past the buffer means wrap
  assign a_inc    = ar_i + W'(1);
  assign inc_wrap = {1'b0, a_inc ^ ar_i} >= {wr_i, 1'b1};

  assign a_dec    = ar_i - W'(1);
  assign t_dec    = am_s - XW'(1);
  assign dec_wrap = t_dec < lim_s;

  assign a_add    = ar_i + ix_i;
  assign t_add    = am_s + xm_s - m_s - XW'(1);
  assign add_fwd  = !ix_i[W-1] && !t_add[XW-1];
  assign add_back = ix_i[W-1] && (t_add < lim_s);

  assign a_sub    = ar_i - ix_i;
  assign t_sub    = am_s - xm_s;
  assign sub_neg  = ix_i[W-1] && (|ix_i[W-2:0]);
  assign sub_fwd  = sub_neg && !t_sub[XW-1];
  assign sub_back = !sub_neg && (t_sub < lim_s);

  always_comb begin
    unique case (op_i)
      OP_INC:   nar_o = inc_wrap ? a_inc - wr_p1 : a_inc;
      OP_DEC:   nar_o = dec_wrap ? a_dec + wr_p1 : a_dec;
      OP_ADDIX: nar_o = add_fwd ? a_add - wr_p1 : (add_back ? a_add + wr_p1 : a_add);
      OP_SUBIX: nar_o = sub_fwd ? a_sub - wr_p1 : (sub_back ? a_sub + wr_p1 : a_sub);
      default:  nar_o = ar_i;
    endcase
  end
endmodule

// File: rtl/agu_regfile.sv
module agu_regfile #(
  parameter int W     = 16,
  parameter int N     = 4,
  parameter int IDX_W = $clog2(N),
  parameter int SEL_W = $clog2(3 * N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [SEL_W-1:0]    wr_sel_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic                upd_en_i,
  input  logic [IDX_W-1:0]    upd_idx_i,
  input  logic [W-1:0]        upd_val_i,
  output logic [N-1:0][W-1:0] ar_o,
  output logic [N-1:0][W-1:0] ix_o,
  output logic [N-1:0][W-1:0] wr_o
);
  logic [W-1:0] ar_q [N];
  logic [W-1:0] ix_q [N];
  logic [W-1:0] wr_q [N];

  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          ar_q[g] <= '0;
      else if (upd_en_i && upd_idx_i == IDX_W'(g))          ar_q[g] <= upd_val_i;
      else if (wr_en_i && wr_sel_i == SEL_W'(g))            ar_q[g] <= wr_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          ix_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(g + N))        ix_q[g] <= wr_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          wr_q[g] <= '0;
      else if (wr_en_i && wr_sel_i == SEL_W'(g + 2 * N))    wr_q[g] <= wr_data_i;
    end
    assign ar_o[g] = ar_q[g];
    assign ix_o[g] = ix_q[g];
    assign wr_o[g] = wr_q[g];
  end
endmodule

// File: rtl/modulo_agu.sv
module modulo_agu
  import agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int NUM_AR = 4,
  localparam int IDX_W = $clog2(NUM_AR),
  localparam int SEL_W = $clog2(3 * NUM_AR)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [15:0]       op_code_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              idx_flag_o
);
  agu_op_e                      op_kind;
  logic [IDX_W-1:0]             dst, src;
  logic                         go;
  logic [NUM_AR-1:0][ADDR_W-1:0] ar_all, ix_all, wr_all;
  logic [ADDR_W-1:0]            nar;
  logic [ADDR_W-1:0]            addr_q;
  logic                         done_q, flag_q;

  assign dst = op_code_i[IDX_W-1:0];
  assign src = op_code_i[2*IDX_W-1:IDX_W];

  always_comb begin
    op_kind = OP_NONE;
    if      ((op_code_i & 16'hFFFC) == 16'h0004) op_kind = OP_DEC;
    else if ((op_code_i & 16'hFFFC) == 16'h0008) op_kind = OP_INC;
    else if ((op_code_i & 16'hFFFC) == 16'h000C) op_kind = OP_SUBIX;
    else if ((op_code_i & 16'hFFF0) == 16'h0010) op_kind = OP_ADDIX;
  end

  assign go = op_valid_i && (op_kind != OP_NONE);

  agu_regfile #(.W(ADDR_W), .N(NUM_AR)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .upd_en_i  (go),
    .upd_idx_i (dst),
    .upd_val_i (nar),
    .ar_o      (ar_all),
    .ix_o      (ix_all),
    .wr_o      (wr_all)
  );

  agu_next #(.W(ADDR_W)) u_next (
    .op_i  (op_kind),
    .ar_i  (ar_all[dst]),
    .ix_i  (ix_all[dst]),
    .wr_i  (wr_all[dst]),
    .nar_o (nar)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      done_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      done_q <= go;
      flag_q <= go && (op_kind == OP_ADDIX) && (src != dst);
      if (go) addr_q <= nar;
    end
  end

  assign addr_o     = addr_q;
  assign done_o     = done_q;
  assign idx_flag_o = flag_q;
endmodule

// File: rtl/agu_checker.sv
module agu_checker #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         op_valid_i,
  input logic [15:0]  op_code_i,
  input logic [W-1:0] addr_o,
  input logic         done_o,
  input logic         idx_flag_o
);
  AST_DONE_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(op_valid_i)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!done_o && $stable(addr_o))); // R9
  AST_FLAG_ONLY_ADDIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_flag_o |-> (done_o && $past(op_code_i[15:4]) == 12'h001)); // R8
  AST_UNKNOWN_OP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i[15:5] != 11'd0) |=> (!done_o && $stable(addr_o))); // R2
  AST_ADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown({addr_o, done_o, idx_flag_o})); // R10
endmodule

bind modulo_agu agu_checker #(.W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .op_valid_i (op_valid_i),
  .op_code_i  (op_code_i),
  .addr_o     (addr_o),
  .done_o     (done_o),
  .idx_flag_o (idx_flag_o)
);

// File: tb/tb_modulo_agu.sv
`timescale 1ns/1ps
module tb_modulo_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] op_code = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] addr;
  logic        done, flag;
  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  modulo_agu dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .addr_o(addr), .done_o(done), .idx_flag_o(flag)
  );

  // {opcode, ar, ix, wr, expected}
  localparam int NV = 17;
  localparam logic [79:0] VEC [NV] = '{
    {16'h0008, 16'h0003, 16'h0000, 16'h0003, 16'h0000},
    {16'h0009, 16'h0001, 16'h0000, 16'h0003, 16'h0002},
    {16'h0006, 16'h0000, 16'h0000, 16'h0003, 16'h0003},
    {16'h0007, 16'h0002, 16'h0000, 16'h0003, 16'h0001},
    {16'h0008, 16'h0005, 16'h0000, 16'h0000, 16'h0005},
    {16'h0004, 16'h0005, 16'h0000, 16'h0000, 16'h0005},
    {16'h0015, 16'h0010, 16'h0002, 16'h0007, 16'h0012},
    {16'h001A, 16'h0016, 16'h0003, 16'h0007, 16'h0011},
    {16'h001F, 16'h0011, 16'hFFFD, 16'h0007, 16'h0016},
    {16'h000C, 16'h0011, 16'h0003, 16'h0007, 16'h0016},
    {16'h000D, 16'h0016, 16'hFFFE, 16'h0007, 16'h0010},
    {16'h000E, 16'h0011, 16'h8000, 16'h0007, 16'h8011},
    {16'h0010, 16'h0015, 16'h0000, 16'h0007, 16'h0015},
    {16'h0008, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h0000},
    {16'h0004, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF},
    {16'h0004, 16'h0020, 16'h0000, 16'h0005, 16'h0025},
    {16'h001F, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0000}
  };

  function automatic string tag_of(input logic [15:0] op);
    if (op[15:4] == 12'h001)  return "R6";
    if (op[3:2] == 2'b01)     return "R5";
    if (op[3:2] == 2'b10)     return "R4";
    return "R7";
  endfunction

  function automatic logic [15:0] ref_next(input logic [15:0] op, ar, ix, wr);
    int a = int'(ar);
    int x = int'(ix);
    int w = int'(wr);
    int m = 1;
    int n;
    int t;
    for (int b = 15; b >= 0; b--) begin
      if (wr[b]) begin
        m = (1 << (b + 1)) - 1;
        break;
      end
    end
    if (op[15:4] == 12'h001) begin
      n = a + x;
      t = (a & m) + (x & m) - m - 1;
      if (!ix[15]) begin
        if (t >= 0) n = n - w - 1;
      end else if (t < m - w) n = n + w + 1;
    end else if (op[3:2] == 2'b10) begin
      n = a + 1;
      if (((n & 32'hFFFF) ^ a) >= ((w << 1) | 1)) n = n - w - 1;
    end else if (op[3:2] == 2'b01) begin
      n = a - 1;
      if ((a & m) - 1 < m - w) n = n + w + 1;
    end else begin
      n = a - x;
      t = (a & m) - (x & m);
      if (x > 32'h8000) begin
        if (t >= 0) n = n - w - 1;
      end else if (t < m - w) n = n + w + 1;
    end
    return n[15:0];
  endfunction

  task automatic check(input string tag, input string what, input logic [15:0] act, exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_op(input logic [15:0] op);
    @(negedge clk);
    op_valid = 1'b1; op_code = op;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic run_vec(input logic [15:0] op, ar, ix, wr, exp, input string tag);
    logic [1:0] d = op[1:0];
    load({2'b00, d}, ar);
    load({2'b01, d}, ix);
    load({2'b10, d}, wr);
    do_op(op);
    check(tag, "addr", addr, exp);
    check("R9", "done", {15'd0, done}, 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] wsel [7];
    logic [15:0] isel [6];
    wsel = '{16'h0000, 16'h0001, 16'h0003, 16'h0007, 16'h001F, 16'hFFFF, 16'h00A0};
    isel = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h7FFF, 16'h0005};

    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "addr", addr, 16'h0000);
    check("R10", "done", {15'd0, done}, 16'd0);
    check("R10", "flag", {15'd0, flag}, 16'd0);
    rst_n = 1'b1;
    do_op(16'h0008);
    check("R10", "ar0 after reset", addr, 16'h0000);

    // table walk: R4 R5 R6 R7 R3 R12
    for (int i = 0; i < NV; i++) begin
      logic [79:0] v = VEC[i];
      run_vec(v[79:64], v[63:48], v[47:32], v[31:16], v[15:0], tag_of(v[79:64]));
    end
    // R3: wr=0 keeps address fixed, wr=5 gives mask 7
    run_vec(16'h000B, 16'h1234, 16'h0000, 16'h0000, 16'h1234, "R3");
    run_vec(16'h0004, 16'h0027, 16'h0000, 16'h0005, 16'h0026, "R3");
    // R12: 16-bit modulo on add
    run_vec(16'h0010, 16'hFFF0, 16'h0020, 16'hFFFF, 16'h0010, "R12");

    // R9: next cycle without an op holds addr, done low
    @(negedge clk);
    check("R9", "done idle", {15'd0, done}, 16'd0);
    check("R9", "addr hold", addr, 16'h0010);

    // R2: unrecognised opcode ignored
    load(4'd0, 16'h0040);
    load(4'd8, 16'h0000);
    do_op(16'h0008);
    check("R2", "setup", addr, 16'h0040);
    do_op(16'h0020);
    check("R2", "done on bad op", {15'd0, done}, 16'd0);
    check("R2", "addr on bad op", addr, 16'h0040);
    do_op(16'h0001);
    check("R2", "done on code 1", {15'd0, done}, 16'd0);
    do_op(16'h0008);
    check("R2", "ar0 unchanged", addr, 16'h0040);

    // R1: selects 12..15 change nothing
    load(4'd4, 16'h0003);
    for (int s = 12; s < 16; s++) load(4'(s), 16'h5555);
    do_op(16'h0010);
    check("R1", "ix0 via add", addr, 16'h0043);
    do_op(16'h0008);
    check("R1", "wr0 still zero", addr, 16'h0043);

    // R8: mismatched source field
    load(4'd1, 16'h0010);
    load(4'd5, 16'h0002);
    load(4'd9, 16'h0007);
    load(4'd6, 16'h0005);
    do_op(16'h0019);
    check("R8", "uses ix1", addr, 16'h0012);
    check("R8", "flag set", {15'd0, flag}, 16'd1);
    do_op(16'h0015);
    check("R8", "flag clear", {15'd0, flag}, 16'd0);
    check("R8", "matched add", addr, 16'h0014);

    // R11: op beats same-cycle write to its address register
    @(negedge clk);
    op_valid = 1'b1; op_code = 16'h0009;
    wr_en = 1'b1; wr_sel = 4'd1; wr_data = 16'h0500;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    check("R11", "op result", addr, 16'h0015);
    do_op(16'h0009);
    check("R11", "write dropped", addr, 16'h0016);
    // R11: same-cycle write of wr register is seen only afterwards
    @(negedge clk);
    op_valid = 1'b1; op_code = 16'h0009;
    wr_en = 1'b1; wr_sel = 4'd9; wr_data = 16'h0000;
    @(negedge clk);
    op_valid = 1'b0; wr_en = 1'b0;
    check("R11", "old wr used", addr, 16'h0017);
    do_op(16'h0009);
    check("R11", "new wr used", addr, 16'h0017);

    // random sweep against the reference: R4 R5 R6 R7
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ar = 16'($urandom);
      logic [15:0] ix = ($urandom % 3 == 0) ? 16'($urandom) : isel[$urandom % 6];
      logic [15:0] wr = ($urandom % 4 == 0) ? 16'($urandom) : wsel[$urandom % 7];
      logic [1:0]  d  = 2'($urandom);
      logic [15:0] op;
      case ($urandom % 4)
        0: op = {14'h0001, d};
        1: op = {14'h0002, d};
        2: op = {14'h0003, d};
        default: op = {12'h001, d, d};
      endcase
      run_vec(op, ar, ix, wr, ref_next(op, ar, ix, wr), tag_of(op));
    end

    // R10: mid-run reset clears registers
    load(4'd2, 16'h1234);
    load(4'd10, 16'h0000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10", "addr in reset", addr, 16'h0000);
    rst_n = 1'b1;
    do_op(16'h000A);
    check("R10", "ar2 cleared", addr, 16'h0000);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule